// File: doc/BRIEF.md
# Serial Trim Register Bank

This block is a serial-bus slave that holds the trim and setup bytes of an analog chip. An external master writes or reads the bytes over a four-wire SPI link in mode 0. All bytes drive the analog circuits through one wide parallel output at all times. The serial clock, data input and active-low select are treated as asynchronous. Each is synchronized into a system clock that runs at least eight times faster than the serial clock.

Each transaction carries three bytes in a fixed order, each sent most significant bit first: an opcode, a register index, then a data byte. A write does not pass through the live trim byte. Incoming bits collect in private shift registers, and the target byte changes in a single system-clock step only when the last data bit arrives. A trim DAC therefore never sees a partly shifted value. A read returns the indexed byte on the data output during the data phase.

Top module: `spi_trim_bank`

## Requirements
- R1: After reset every register is 0x00, `trim_out` is all zeros and `miso` is 0.
- R2: While `cs_n` is low, a bit is taken from `mosi` on each rising `sclk` edge, most significant bit first. Bits 1 to 8 form the opcode, bits 9 to 16 the index and bits 17 to 24 the data byte.
- R3: Opcode 0x02 with an index below 10 loads the data byte into that register. Register k appears on `trim_out[8k+7:8k]`.
- R4: A register's output stays unchanged during a frame. It takes its new value, all eight bits at once, within four system clocks after the 24th rising `sclk` edge.
- R5: Opcode 0x03 returns the indexed register on `miso`, most significant bit first. The first bit is valid after the falling edge that follows bit 16. Each later bit changes on a falling edge and is valid at the next rising edge.
- R6: An opcode other than 0x02 or 0x03 changes no register and leaves `miso` at 0.
- R7: A write with an index of 10 or higher changes no register. A read with such an index returns 0x00.
- R8: If `cs_n` rises before the 24th bit, the frame is discarded and no register changes.
- R9: Bits after the 24th in one frame are ignored. `miso` is 0 outside the data phase of a read.
- R10: All ten registers are presented on `trim_out` at the same time, and a write to one register leaves the other nine unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master (idle low) |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Active-low chip select |
| miso | output | 1 | Serial data to the master |
| trim_out | output | 80 | Ten trim bytes in parallel, register k at bits 8k+7..8k |

## Verification
Every serial edge takes about four system clocks to act: two synchronizer stages, one edge-detect stage and the register itself. The bench holds each `sclk` level for ten system clocks and changes inputs on the falling system edge, so each effect has settled before the next sample. `miso` is read just before each rising `sclk` edge, the point where a mode-0 master samples it. `trim_out` is compared after `cs_n` has been high for a dozen cycles. One mid-frame sample, taken after bit 20, confirms that the write has not yet reached the output.

// File: rtl/spi_trim_bank.sv
module spi_trim_bank #(
  parameter int NREG = 10,
  parameter int BW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 mosi,
  input  logic                 cs_n,
  output logic                 miso,
  output logic [NREG*BW-1:0]   trim_out
);
  localparam int FRAME = 3 * BW;
  localparam int CW    = $clog2(FRAME + 1);
  localparam int IW    = $clog2(NREG);
  localparam logic [BW-1:0] OP_WR = BW'(8'h02);
  localparam logic [BW-1:0] OP_RD = BW'(8'h03);

  logic [1:0] sclk_sy, mosi_sy, cs_sy;
  logic       sclk_d;
  logic [CW-1:0] bitcnt;
  logic [BW-1:0] op_sh, idx_sh, dat_sh, tx_sh;
  logic [BW-1:0] bank [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0;
      mosi_sy <= '0;
      cs_sy   <= '1;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[0], sclk};
      mosi_sy <= {mosi_sy[0], mosi};
      cs_sy   <= {cs_sy[0], cs_n};
      sclk_d  <= sclk_sy[1];
    end

  wire sel      = ~cs_sy[1];
  wire din      = mosi_sy[1];
  wire rise     = sel & sclk_sy[1] & ~sclk_d;
  wire fall     = sel & ~sclk_sy[1] & sclk_d;
  wire idx_ok   = idx_sh < BW'(NREG);
  wire last_bit = rise && (bitcnt == CW'(FRAME - 1));
  wire commit   = last_bit && (op_sh == OP_WR) && idx_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0;
      op_sh  <= '0;
      idx_sh <= '0;
      dat_sh <= '0;
    end else if (!sel) begin
      bitcnt <= '0;
    end else if (rise && bitcnt < CW'(FRAME)) begin
      bitcnt <= bitcnt + 1'b1;
      if (bitcnt < CW'(BW))          op_sh  <= {op_sh[BW-2:0], din};
      else if (bitcnt < CW'(2 * BW)) idx_sh <= {idx_sh[BW-2:0], din};
      else                           dat_sh <= {dat_sh[BW-2:0], din};
    end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) bank[g] <= '0;
        else if (commit && idx_sh == BW'(g)) bank[g] <= {dat_sh[BW-2:0], din};
      assign trim_out[g*BW +: BW] = bank[g];
    end
  endgenerate

  wire [BW-1:0] rd_val = idx_ok ? bank[idx_sh[IW-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_sh <= '0;
    else if (!sel) tx_sh <= '0;
    else if (fall && bitcnt == CW'(2 * BW))
      tx_sh <= (op_sh == OP_RD) ? rd_val : '0;
    else if (fall && bitcnt > CW'(2 * BW))
      tx_sh <= {tx_sh[BW-2:0], 1'b0};

  assign miso = tx_sh[BW-1];

  a_r1_idle_miso: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sy[1] && $past(cs_sy[1])) |-> !miso);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= CW'(FRAME));
  a_r4_atomic_update: assert property (@(posedge clk) disable iff (!rst_n)
    !last_bit |=> $stable(trim_out));
  a_r6_bad_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && op_sh != OP_WR) |=> $stable(trim_out));
  a_r7_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && !idx_ok) |=> $stable(trim_out));
  a_r8_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sy[1] |=> bitcnt == '0);
endmodule

// File: tb/spi_trim_bank_tb_top.sv
module spi_trim_bank_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso;
  logic [79:0] trim_out;
  logic [7:0] model [10];
  int vec = 0, bad = 0;
  localparam int H = 10;

  always #4 clk = ~clk;

  spi_trim_bank dut_i (.clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .miso(miso), .trim_out(trim_out));

  function automatic logic [79:0] exp_bus();
    logic [79:0] v;
    for (int k = 0; k < 10; k++) v[k*8 +: 8] = model[k];
    return v;
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] op, input logic [7:0] idx, input logic [7:0] dat,
                      input int nbits, output logic [7:0] rd, output int stray);
    logic [23:0] fr;
    fr = {op, idx, dat};
    rd = '0;
    stray = 0;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? fr[23-i] : 1'b1;
      wait_clk(H);
      if (i >= 16 && i < 24) rd = {rd[6:0], miso};
      else if (miso) stray++;
      if (i == 20) chk("R4 mid-frame hold", trim_out, exp_bus());
      sclk = 1'b1;
      wait_clk(H);
      sclk = 1'b0;
    end
    wait_clk(H);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(12);
  endtask

  task automatic t_reset();
    chk("R1 trim reset", trim_out, '0);
    chk("R1 miso reset", {79'd0, miso}, '0);
  endtask

  task automatic t_write();
    logic [7:0] rd; int s;
    xfer(8'h02, 8'd3, 8'hA5, 24, rd, s); model[3] = 8'hA5;
    chk("R3 write reg3", trim_out, exp_bus());
    xfer(8'h02, 8'd0, 8'h3C, 24, rd, s); model[0] = 8'h3C;
    xfer(8'h02, 8'd9, 8'hF1, 24, rd, s); model[9] = 8'hF1;
    chk("R10 parallel regs 0,3,9", trim_out, exp_bus());
    chk("R9 miso low on write", {48'd0, s[31:0]}, '0);
  endtask

  task automatic t_read();
    logic [7:0] rd; int s;
    xfer(8'h03, 8'd3, 8'h00, 24, rd, s);
    chk("R5 read reg3", {72'd0, rd}, {72'd0, 8'hA5});
    chk("R9 miso low outside data", {48'd0, s[31:0]}, '0);
    xfer(8'h03, 8'd9, 8'hFF, 24, rd, s);
    chk("R5 read reg9", {72'd0, rd}, {72'd0, 8'hF1});
    chk("R2 read leaves regs", trim_out, exp_bus());
  endtask

  task automatic t_bad_op();
    logic [7:0] rd; int s;
    xfer(8'h07, 8'd2, 8'h55, 24, rd, s);
    chk("R6 bad opcode no write", trim_out, exp_bus());
    chk("R6 bad opcode miso low", {72'd0, rd}, '0);
  endtask

  task automatic t_range();
    logic [7:0] rd; int s;
    xfer(8'h02, 8'd10, 8'hFF, 24, rd, s);
    chk("R7 index 10 write ignored", trim_out, exp_bus());
    xfer(8'h03, 8'd12, 8'h00, 24, rd, s);
    chk("R7 index 12 reads zero", {72'd0, rd}, '0);
  endtask

  task automatic t_abort();
    logic [7:0] rd; int s;
    xfer(8'h02, 8'd5, 8'h77, 20, rd, s);
    chk("R8 short frame discarded", trim_out, exp_bus());
    xfer(8'h02, 8'd5, 8'h5A, 24, rd, s); model[5] = 8'h5A;
    chk("R8 next frame clean", trim_out, exp_bus());
  endtask

  task automatic t_extra();
    logic [7:0] rd; int s;
    xfer(8'h02, 8'd6, 8'h81, 30, rd, s); model[6] = 8'h81;
    chk("R9 extra bits ignored", trim_out, exp_bus());
    xfer(8'h03, 8'd6, 8'h00, 24, rd, s);
    chk("R2 msb-first readback", {72'd0, rd}, {72'd0, 8'h81});
  endtask

  initial begin
    for (int k = 0; k < 10; k++) model[k] = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write();
    t_read();
    t_bad_op();
    t_range();
    t_abort();
    t_extra();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vec++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule